// File: doc/BRIEF.md
# Sync Trigger Match Unit

This unit keeps a small register of synchronisation trigger bits on behalf of one DMA channel. When the channel reaches a sync descriptor, it presents that descriptor on a command port: a set mask, a clear mask, a match value and a match-enable mask. The unit applies both masks to the trigger register on the accepting clock edge. From the next cycle on, it compares the enabled trigger bits against the match value and holds the channel until they agree.

External hardware event lines can also set or clear trigger bits. Two per-bit enable registers gate them: one for set events and one for clear events. Both are zero after reset, so no event has any effect until software-visible logic elsewhere writes them. An event can therefore resume a channel that a sync descriptor has paused.

Top module: `sync_trigger_unit`

## Requirements
- R1: After a synchronous active-low reset, `trig_bits` is 0x00, `waiting` is 0 and `proceed` is 0.
- R2: A command is accepted when `cmd_valid` is high while `waiting` is low. On that clock edge every bit i of `cmd_set_mask` sets trigger bit i and every bit i of `cmd_clr_mask` clears trigger bit i. The result is visible on `trig_bits` in the next cycle.
- R3: If any source (descriptor or enabled event) sets a trigger bit and any source clears the same bit on the same edge, the bit ends up 0.
- R4: In the cycle after acceptance, `waiting` is 1. `proceed` is 1 in every waiting cycle where `(trig_bits & match_en) == (match_val & match_en)` holds with the stored match fields, and 0 otherwise. A match-enable of 0x00 gives `proceed` in the first waiting cycle.
- R5: `proceed` lasts one cycle, and `waiting` is 0 in the cycle after it.
- R6: A high `evt_set[i]` sets trigger bit i only when set-enable bit i is 1. A high `evt_clr[i]` clears trigger bit i only when clear-enable bit i is 1. Other event bits leave the register unchanged.
- R7: Set-enable and clear-enable are loaded from `set_en_din` and `clr_en_din` on edges where `set_en_wr` and `clr_en_wr` are high, respectively. Both are 0x00 after reset, so events have no effect until the registers are written.
- R8: A `cmd_valid` while `waiting` is 1 is ignored: its masks are not applied and the stored match fields do not change.
- R9: While waiting, enabled events update the trigger bits, and `proceed` rises in the cycle after an event makes the masked comparison true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_en_wr | input | 1 | Load strobe for the set-enable register |
| set_en_din | input | 8 | New set-enable value |
| clr_en_wr | input | 1 | Load strobe for the clear-enable register |
| clr_en_din | input | 8 | New clear-enable value |
| cmd_valid | input | 1 | Sync descriptor present |
| cmd_set_mask | input | 8 | Descriptor bits to set |
| cmd_clr_mask | input | 8 | Descriptor bits to clear |
| cmd_match_val | input | 8 | Value to wait for |
| cmd_match_en | input | 8 | Bits taking part in the comparison |
| evt_set | input | 8 | Hardware set event per bit |
| evt_clr | input | 8 | Hardware clear event per bit |
| trig_bits | output | 8 | Current trigger register |
| waiting | output | 1 | Channel is stalled on a sync descriptor |
| proceed | output | 1 | Masked match reached; channel may continue |

## Verification
The hardest case to reach from the ports is a waiting channel that an external event releases while a second descriptor is knocking on the command port. It needs the enable registers written while the unit is stalled, a rejected command, and then an enabled event pulse. The directed stimulus first parks the unit on a match the register cannot meet and offers a conflicting command. It then writes set-enable and pulses one event bit, checking both the ignored command and the one-cycle release. Same-edge set/clear conflicts are reached by putting descriptor masks and event pulses in the same accepting cycle.

// File: rtl/sync_trig_pkg.sv
// Shared types for the sync trigger match unit.
// Assumes nothing beyond a single clock domain.
package sync_trig_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;
endpackage

// File: rtl/sync_en_regs.sv
// Holds the per-bit enables that gate hardware set and clear events.
// Assumes the write strobes are synchronous to clk; both reset to zero.
module sync_en_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en_wr,
    input  logic [W-1:0] set_en_din,
    input  logic         clr_en_wr,
    input  logic [W-1:0] clr_en_din,
    output logic [W-1:0] set_en,
    output logic [W-1:0] clr_en
);
    // Load the set-event enable on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         set_en <= '0;
        else if (set_en_wr) set_en <= set_en_din;
    end

    // Load the clear-event enable on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         clr_en <= '0;
        else if (clr_en_wr) clr_en <= clr_en_din;
    end
endmodule

// File: rtl/sync_trig_reg.sv
// Trigger bit register. Merges descriptor masks with gated event lines;
// clear has priority over set on each bit.
// Assumes desc_apply is high only on the accepting edge of a command.
module sync_trig_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         desc_apply,
    input  logic [W-1:0] desc_set,
    input  logic [W-1:0] desc_clr,
    input  logic [W-1:0] evt_set,
    input  logic [W-1:0] evt_clr,
    input  logic [W-1:0] set_en,
    input  logic [W-1:0] clr_en,
    output logic [W-1:0] trig
);
    logic [W-1:0] set_any;
    logic [W-1:0] clr_any;

    // Gather all set and clear requests for this edge.
    always_comb begin
        set_any = (desc_apply ? desc_set : '0) | (evt_set & set_en);
        clr_any = (desc_apply ? desc_clr : '0) | (evt_clr & clr_en);
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Update one trigger bit, clear winning over set.
        always_ff @(posedge clk) begin
            if (!rst_n)          trig[i] <= 1'b0;
            else if (clr_any[i]) trig[i] <= 1'b0;
            else if (set_any[i]) trig[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/sync_wait_ctl.sv
// Accepts a sync descriptor when idle, latches its match fields and
// stalls until the enabled trigger bits equal the match value.
// Assumes trig already reflects the descriptor masks one cycle after accept.
module sync_wait_ctl
    import sync_trig_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [W-1:0] cmd_val,
    input  logic [W-1:0] cmd_en,
    input  logic [W-1:0] trig,
    output logic         accept,
    output logic         waiting,
    output logic         proceed
);
    phase_e       phase;
    logic [W-1:0] val_q;
    logic [W-1:0] en_q;
    logic         hit;

    // Compare enabled trigger bits with the stored match value.
    always_comb begin
        hit     = ((trig ^ val_q) & en_q) == '0;
        waiting = (phase == PH_WAIT);
        accept  = cmd_valid && (phase == PH_IDLE);
        proceed = waiting && hit;
    end

    // Sequence idle -> wait -> idle and hold the match fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            val_q <= '0;
            en_q  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (cmd_valid) begin
                    val_q <= cmd_val;
                    en_q  <= cmd_en;
                    phase <= PH_WAIT;
                end
                PH_WAIT: if (hit) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sync_trigger_unit.sv
// Top of the sync trigger match unit: enable registers, trigger register
// and the wait controller. Assumes one channel drives the command port.
module sync_trigger_unit #(
    parameter int TRIG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en_wr,
    input  logic [TRIG_W-1:0] set_en_din,
    input  logic              clr_en_wr,
    input  logic [TRIG_W-1:0] clr_en_din,
    input  logic              cmd_valid,
    input  logic [TRIG_W-1:0] cmd_set_mask,
    input  logic [TRIG_W-1:0] cmd_clr_mask,
    input  logic [TRIG_W-1:0] cmd_match_val,
    input  logic [TRIG_W-1:0] cmd_match_en,
    input  logic [TRIG_W-1:0] evt_set,
    input  logic [TRIG_W-1:0] evt_clr,
    output logic [TRIG_W-1:0] trig_bits,
    output logic              waiting,
    output logic              proceed
);
    logic [TRIG_W-1:0] set_en_q;
    logic [TRIG_W-1:0] clr_en_q;
    logic              accept;

    sync_en_regs #(.W(TRIG_W)) u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en_wr  (set_en_wr),
        .set_en_din (set_en_din),
        .clr_en_wr  (clr_en_wr),
        .clr_en_din (clr_en_din),
        .set_en     (set_en_q),
        .clr_en     (clr_en_q)
    );

    sync_trig_reg #(.W(TRIG_W)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_apply (accept),
        .desc_set   (cmd_set_mask),
        .desc_clr   (cmd_clr_mask),
        .evt_set    (evt_set),
        .evt_clr    (evt_clr),
        .set_en     (set_en_q),
        .clr_en     (clr_en_q),
        .trig       (trig_bits)
    );

    sync_wait_ctl #(.W(TRIG_W)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_val   (cmd_match_val),
        .cmd_en    (cmd_match_en),
        .trig      (trig_bits),
        .accept    (accept),
        .waiting   (waiting),
        .proceed   (proceed)
    );
endmodule

// File: rtl/sync_trigger_unit_chk.sv
// Property checker for sync_trigger_unit, attached by bind below.
module sync_trigger_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic [W-1:0] cmd_set_mask,
    input logic [W-1:0] cmd_clr_mask,
    input logic [W-1:0] evt_set,
    input logic [W-1:0] evt_clr,
    input logic [W-1:0] set_en,
    input logic [W-1:0] clr_en,
    input logic [W-1:0] trig_bits,
    input logic         waiting,
    input logic         proceed
);
    logic take;
    assign take = cmd_valid && !waiting;

    p_wait_after_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> waiting);

    p_proceed_needs_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        proceed |-> waiting);

    p_single_proceed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        proceed |=> !waiting);

    p_desc_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ((trig_bits & $past(cmd_clr_mask)) == '0));

    p_desc_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ((evt_clr & clr_en) == '0)) |=>
        ((($past(cmd_set_mask) & ~$past(cmd_clr_mask)) & ~trig_bits) == '0));

    p_quiet_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && ((evt_set & set_en) == '0) && ((evt_clr & clr_en) == '0))
        |=> $stable(trig_bits));

    p_ignore_busy_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && waiting && !proceed && evt_set == '0 && evt_clr == '0)
        |=> (waiting && $stable(trig_bits)));
endmodule

bind sync_trigger_unit sync_trigger_unit_chk #(.W(TRIG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_set_mask (cmd_set_mask),
    .cmd_clr_mask (cmd_clr_mask),
    .evt_set      (evt_set),
    .evt_clr      (evt_clr),
    .set_en       (set_en_q),
    .clr_en       (clr_en_q),
    .trig_bits    (trig_bits),
    .waiting      (waiting),
    .proceed      (proceed)
);

// File: tb/tb_sync_trigger_unit.sv
`timescale 1ns/1ps
module tb_sync_trigger_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_en_wr = 1'b0, clr_en_wr = 1'b0, cmd_valid = 1'b0;
    logic [7:0] set_en_din = '0, clr_en_din = '0;
    logic [7:0] cmd_set_mask = '0, cmd_clr_mask = '0, cmd_match_val = '0, cmd_match_en = '0;
    logic [7:0] evt_set = '0, evt_clr = '0;
    logic [7:0] trig_bits;
    logic       waiting, proceed;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_trigger_unit dut (
        .clk(clk), .rst_n(rst_n),
        .set_en_wr(set_en_wr), .set_en_din(set_en_din),
        .clr_en_wr(clr_en_wr), .clr_en_din(clr_en_din),
        .cmd_valid(cmd_valid), .cmd_set_mask(cmd_set_mask), .cmd_clr_mask(cmd_clr_mask),
        .cmd_match_val(cmd_match_val), .cmd_match_en(cmd_match_en),
        .evt_set(evt_set), .evt_clr(evt_clr),
        .trig_bits(trig_bits), .waiting(waiting), .proceed(proceed)
    );

    // Fields: set_en, clr_en, set, clr, match_val, match_en, evt_set, evt_clr, exp_trig, exp_go
    localparam logic [79:0] VEC [9] = '{
        {8'h00, 8'h00, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h01}, // R2 R4 zero enable
        {8'h00, 8'h00, 8'hF0, 8'h03, 8'hF0, 8'hF0, 8'h00, 8'h00, 8'hFC, 8'h01}, // R2 masked match
        {8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'hFC, 8'h00}, // R3 same-bit conflict
        {8'h0F, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h0F, 8'hFF, 8'h00, 8'h0F, 8'h01}, // R6 gated set
        {8'h00, 8'h30, 8'hF0, 8'h00, 8'hC0, 8'hF0, 8'h00, 8'hFF, 8'hCF, 8'h01}, // R6 gated clear
        {8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'hCE, 8'h01}, // R3 event conflict
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h80, 8'hFF, 8'hFF, 8'hCE, 8'h01}, // R6 disabled events
        {8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h01}, // R2 full clear
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h55, 8'h55, 8'h00, 8'h00, 8'h00, 8'h00}  // R4 stall
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 trig", trig_bits, 8'h00);
        check("R1 waiting", {7'b0, waiting}, 8'h00);
        check("R1 proceed", {7'b0, proceed}, 8'h00);
        // R7 enables are zero after reset: events have no effect
        evt_set = 8'hFF;
        @(negedge clk); evt_set = 8'h00;
        check("R7 events ignored after reset", trig_bits, 8'h00);

        // Vector table walk
        for (int k = 0; k < 9; k++) begin
            logic [79:0] v;
            v = VEC[k];
            @(negedge clk);
            set_en_wr = 1'b1; set_en_din = v[79:72];
            clr_en_wr = 1'b1; clr_en_din = v[71:64];
            @(negedge clk);
            set_en_wr = 1'b0; clr_en_wr = 1'b0;
            cmd_valid = 1'b1;
            cmd_set_mask = v[63:56]; cmd_clr_mask = v[55:48];
            cmd_match_val = v[47:40]; cmd_match_en = v[39:32];
            evt_set = v[31:24]; evt_clr = v[23:16];
            @(negedge clk);
            cmd_valid = 1'b0; evt_set = '0; evt_clr = '0;
            check($sformatf("R2/R3/R6 vec%0d trig", k), trig_bits, v[15:8]);
            check($sformatf("R4 vec%0d proceed", k), {7'b0, proceed}, v[7:0]);
            if (v[0] == 1'b0) begin
                @(negedge clk);
                check($sformatf("R4 vec%0d still stalled", k), {6'b0, waiting, proceed}, 8'h02);
                do_reset();
            end
        end

        // R8/R9: park on an unmet match, offer a second command, then release by event
        do_reset();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_set_mask = 8'h00; cmd_clr_mask = 8'h00;
        cmd_match_val = 8'h01; cmd_match_en = 8'h01;
        @(negedge clk);
        cmd_set_mask = 8'h01; cmd_match_en = 8'h00;   // busy command, must be ignored
        @(negedge clk);
        cmd_valid = 1'b0; cmd_set_mask = 8'h00;
        check("R8 busy cmd masks ignored", trig_bits, 8'h00);
        check("R8 busy cmd match unchanged", {6'b0, waiting, proceed}, 8'h02);
        set_en_wr = 1'b1; set_en_din = 8'h01;
        @(negedge clk);
        set_en_wr = 1'b0;
        check("R7 enable write alone no change", trig_bits, 8'h00);
        evt_set = 8'h01;
        @(negedge clk);
        evt_set = 8'h00;
        check("R9 event sets bit", trig_bits, 8'h01);
        check("R9 event releases", {7'b0, proceed}, 8'h01);
        @(negedge clk);
        check("R5 back to idle", {6'b0, waiting, proceed}, 8'h00);

        finish_run();
    end
endmodule